// File: doc/BRIEF.md
# Eye Scan Sequencer with Opening Measurement

This block runs a complete sweep of an on-chip eye monitor and boils the result down to two figures of merit. It drives a phase-offset code and a voltage-offset code into the analog offset sampler. It walks every point of a square grid, with phase in the outer loop and voltage in the inner loop. At each point it dwells for a programmed number of valid sample bits and counts the bits on which the offset sampler disagrees with the main data sampler. Every point then leaves on a valid/ready stream as its coordinates, its hit count and its observed-bit count, so software can turn each point into a hit probability.

Once the grid is finished, the block finds the two crossing positions on the zero-volt row. It then re-measures the single phase column midway between them and reports two results. The horizontal opening is the open run along the zero-volt row, in phase steps, where one unit interval equals the full phase range. The vertical opening is the open run along the midway column, in voltage steps. Both results stay readable until the next accepted start. A start is refused unless the line-rate qualifier is high.

Top module: `eye_scan_seq`

## Requirements
- R1: After reset, busy, done, err, res_valid and pt_valid are all 0.
- R2: A start while idle with rate_ok low does not begin a sweep (busy stays 0) and sets err to 1. An accepted start (rate_ok high) clears err.
- R3: The sweep emits every grid point exactly once, in the order phase 0..NPH-1 outer and voltage 0..NV-1 inner. ph_code and v_code show the coordinates of the point being emitted.
- R4: Each point dwells for exactly 2^dwell_log valid samples (smp_valid high), and pt_bits reports that count.
- R5: pt_hits counts the dwell samples with smp_off different from smp_main, and holds at 2^HIT_W-1 rather than wrapping.
- R6: While pt_valid is high and pt_ready is low, the sweep holds, and pt_valid and the whole payload stay unchanged.
- R7: A point is open when its hit count is less than or equal to hit_thresh.
- R8: heo is the length of the contiguous run of open points on the zero-volt row (voltage index NV/2) that contains phase index NPH/2. It is 0 when that centre point is not open.
- R9: The measured column is floor((first closed phase + last closed phase)/2) on the zero-volt row, or NPH/2 when that row has no closed point. veo is the open run in that column that contains voltage index NV/2, or 0 when the centre point is closed.
- R10: busy is high from an accepted start until res_valid rises. done is a one-cycle pulse in the cycle res_valid rises. res_valid is cleared by an accepted start.
- R11: A start while busy is ignored: the sweep, its order and its settings continue unchanged.
- R12: dwell_log, hit_thresh and range_cfg are captured at an accepted start. range_o shows the captured full-scale setting, and input changes during a sweep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Sweep request |
| rate_ok | input | 1 | High when the line rate is 2.97 Gbps or more |
| dwell_log | input | DL_W | Dwell length exponent, bits per point = 2^dwell_log |
| hit_thresh | input | HIT_W | Highest hit count still judged open |
| range_cfg | input | RNG_W | Voltage full-scale setting for the analog side |
| smp_valid | input | 1 | Sampler pair carries a new bit |
| smp_main | input | 1 | Main data sampler bit |
| smp_off | input | 1 | Offset sampler bit |
| ph_code | output | PH_W | Phase-offset code to the offset sampler |
| v_code | output | V_W | Voltage-offset code to the offset sampler |
| range_o | output | RNG_W | Captured full-scale setting |
| pt_valid | output | 1 | Point record available |
| pt_ready | input | 1 | Consumer accepts the point record |
| pt_ph | output | PH_W | Phase index of the record |
| pt_v | output | V_W | Voltage index of the record |
| pt_hits | output | HIT_W | Saturating hit count |
| pt_bits | output | BITS_W | Bits observed at the point |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was refused for line rate |
| res_valid | output | 1 | heo and veo hold valid results |
| heo | output | PH_W+1 | Horizontal opening in phase steps |
| veo | output | V_W+1 | Vertical opening in voltage steps |

## Verification
The bench builds the block with a 16 by 16 grid (PH_W = V_W = 4), a 3-bit hit counter and an 8-bit bit counter. Full sweeps, including the extra column pass, therefore fit many times into the run, and a dwell of 8 bits on a closed point drives the hit count into saturation at 7. The small grid lets the bench place its modelled eye edges, crossings and a single marginal point on the zero-volt row, on the centre point or away from both. This exercises the open runs that touch the grid border, the case with no crossing, and the case where the centre is closed.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

    typedef enum logic [2:0] {
        SCAN_IDLE   = 3'd0,
        SCAN_DWELL  = 3'd1,
        SCAN_EMIT   = 3'd2,
        SCAN_SETCOL = 3'd3,
        SCAN_CALC   = 3'd4
    } scan_state_e;

endpackage

// File: rtl/eye_scan_dwell.sv
module eye_scan_dwell #(
    parameter int BITS_W = 32,
    parameter int HIT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              smp_valid,
    input  logic              smp_main,
    input  logic              smp_off,
    input  logic [BITS_W-1:0] target,
    output logic [BITS_W-1:0] bits,
    output logic [HIT_W-1:0]  hits,
    output logic              full
);
    localparam logic [BITS_W-1:0] BIT_ONE = BITS_W'(1);
    localparam logic [HIT_W-1:0]  HIT_ONE = HIT_W'(1);
    localparam logic [HIT_W-1:0]  HIT_MAX = '1;

    typedef struct packed {
        logic [BITS_W-1:0] bits;
        logic [HIT_W-1:0]  hits;
    } cnt_t;

    cnt_t c_q, c_d;

    assign full = (c_q.bits == target);
    assign bits = c_q.bits;
    assign hits = c_q.hits;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d = '0;
        end else if (en && smp_valid && !full) begin
            c_d.bits = c_q.bits + BIT_ONE;
            if ((smp_main != smp_off) && (c_q.hits != HIT_MAX))
                c_d.hits = c_q.hits + HIT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end
endmodule

// File: rtl/eye_scan_cross.sv
module eye_scan_cross #(
    parameter int W = 6
) (
    input  logic [(1<<W)-1:0] open_row,
    output logic [W-1:0]      mid
);
    localparam int N = 1 << W;
    localparam logic [W-1:0] CENTRE = W'(N / 2);

    logic [W-1:0] first, last;
    logic         found;
    logic [W:0]   sum;

    always_comb begin
        first = '0;
        last  = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!open_row[i]) begin
                if (!found) first = W'(i);
                last  = W'(i);
                found = 1'b1;
            end
        end
        sum = {1'b0, first} + {1'b0, last};
        mid = found ? sum[W:1] : CENTRE;
    end
endmodule

// File: rtl/eye_scan_run.sv
module eye_scan_run #(
    parameter int W = 6
) (
    input  logic [(1<<W)-1:0] open_line,
    output logic [W:0]        len
);
    localparam int N = 1 << W;
    localparam int C = N / 2;
    localparam logic [W:0] ONE = (W+1)'(1);

    logic [W:0] up, dn;
    logic       go_up, go_dn;

    always_comb begin
        up    = '0;
        dn    = '0;
        go_up = 1'b1;
        go_dn = 1'b1;
        for (int i = C + 1; i < N; i++) begin
            if (go_up && open_line[i]) up = up + ONE;
            else                       go_up = 1'b0;
        end
        for (int i = C - 1; i >= 0; i--) begin
            if (go_dn && open_line[i]) dn = dn + ONE;
            else                       go_dn = 1'b0;
        end
        len = open_line[C] ? (ONE + up + dn) : '0;
    end
endmodule

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
    import eye_scan_pkg::*;
#(
    parameter  int PH_W   = 6,
    parameter  int V_W    = 6,
    parameter  int HIT_W  = 16,
    parameter  int BITS_W = 32,
    parameter  int RNG_W  = 4,
    localparam int DL_W   = $clog2(BITS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rate_ok,
    input  logic [DL_W-1:0]   dwell_log,
    input  logic [HIT_W-1:0]  hit_thresh,
    input  logic [RNG_W-1:0]  range_cfg,
    input  logic              smp_valid,
    input  logic              smp_main,
    input  logic              smp_off,
    output logic [PH_W-1:0]   ph_code,
    output logic [V_W-1:0]    v_code,
    output logic [RNG_W-1:0]  range_o,
    output logic              pt_valid,
    input  logic              pt_ready,
    output logic [PH_W-1:0]   pt_ph,
    output logic [V_W-1:0]    pt_v,
    output logic [HIT_W-1:0]  pt_hits,
    output logic [BITS_W-1:0] pt_bits,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              res_valid,
    output logic [PH_W:0]     heo,
    output logic [V_W:0]      veo
);
    localparam int NPH = 1 << PH_W;
    localparam int NV  = 1 << V_W;
    localparam logic [PH_W-1:0] PH_LAST = '1;
    localparam logic [V_W-1:0]  V_LAST  = '1;
    localparam logic [V_W-1:0]  V_ZERO  = V_W'(NV / 2);
    localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
    localparam logic [V_W-1:0]  V_ONE   = V_W'(1);

    typedef struct packed {
        scan_state_e      state;
        logic             pass2;
        logic [PH_W-1:0]  ph;
        logic [V_W-1:0]   v;
        logic [PH_W-1:0]  col;
        logic [NPH-1:0]   row_open;
        logic [NV-1:0]    col_open;
        logic [DL_W-1:0]  dl;
        logic [HIT_W-1:0] thr;
        logic [RNG_W-1:0] rng;
        logic [PH_W:0]    heo;
        logic [V_W:0]     veo;
        logic             res_valid;
        logic             done;
        logic             err;
    } seq_t;

    seq_t r_q, r_d;

    logic              dw_clr, dw_en, dw_full;
    logic [BITS_W-1:0] dw_bits, dw_target;
    logic [HIT_W-1:0]  dw_hits;
    logic              pt_open;
    logic [PH_W-1:0]   mid_col;
    logic [PH_W:0]     heo_len;
    logic [V_W:0]      veo_len;

    assign dw_target = BITS_W'(1) << r_q.dl;
    assign dw_en     = (r_q.state == SCAN_DWELL);
    assign pt_open   = (dw_hits <= r_q.thr);

    eye_scan_dwell #(.BITS_W(BITS_W), .HIT_W(HIT_W)) u_dwell (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (dw_clr),
        .en        (dw_en),
        .smp_valid (smp_valid),
        .smp_main  (smp_main),
        .smp_off   (smp_off),
        .target    (dw_target),
        .bits      (dw_bits),
        .hits      (dw_hits),
        .full      (dw_full)
    );

    eye_scan_cross #(.W(PH_W)) u_cross (
        .open_row (r_q.row_open),
        .mid      (mid_col)
    );

    eye_scan_run #(.W(PH_W)) u_run_h (
        .open_line (r_q.row_open),
        .len       (heo_len)
    );

    eye_scan_run #(.W(V_W)) u_run_v (
        .open_line (r_q.col_open),
        .len       (veo_len)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        dw_clr   = 1'b0;
        case (r_q.state)
            SCAN_IDLE: begin
                if (start) begin
                    if (rate_ok) begin
                        r_d.state     = SCAN_DWELL;
                        r_d.pass2     = 1'b0;
                        r_d.ph        = '0;
                        r_d.v         = '0;
                        r_d.row_open  = '0;
                        r_d.col_open  = '0;
                        r_d.dl        = dwell_log;
                        r_d.thr       = hit_thresh;
                        r_d.rng       = range_cfg;
                        r_d.res_valid = 1'b0;
                        r_d.err       = 1'b0;
                        dw_clr        = 1'b1;
                    end else begin
                        r_d.err = 1'b1;
                    end
                end
            end
            SCAN_DWELL: begin
                if (dw_full) begin
                    if (!r_q.pass2) begin
                        r_d.state = SCAN_EMIT;
                    end else begin
                        r_d.col_open[r_q.v] = pt_open;
                        dw_clr = 1'b1;
                        if (r_q.v == V_LAST) r_d.state = SCAN_CALC;
                        else                 r_d.v = r_q.v + V_ONE;
                    end
                end
            end
            SCAN_EMIT: begin
                if (pt_ready) begin
                    if (r_q.v == V_ZERO) r_d.row_open[r_q.ph] = pt_open;
                    dw_clr    = 1'b1;
                    r_d.v     = r_q.v + V_ONE;
                    r_d.state = SCAN_DWELL;
                    if (r_q.v == V_LAST) begin
                        r_d.ph = r_q.ph + PH_ONE;
                        if (r_q.ph == PH_LAST) r_d.state = SCAN_SETCOL;
                    end
                end
            end
            SCAN_SETCOL: begin
                r_d.col   = mid_col;
                r_d.pass2 = 1'b1;
                r_d.v     = '0;
                r_d.state = SCAN_DWELL;
                dw_clr    = 1'b1;
            end
            SCAN_CALC: begin
                r_d.heo       = heo_len;
                r_d.veo       = veo_len;
                r_d.res_valid = 1'b1;
                r_d.done      = 1'b1;
                r_d.state     = SCAN_IDLE;
            end
            default: r_d.state = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ph_code   = r_q.pass2 ? r_q.col : r_q.ph;
    assign v_code    = r_q.v;
    assign range_o   = r_q.rng;
    assign pt_valid  = (r_q.state == SCAN_EMIT);
    assign pt_ph     = r_q.ph;
    assign pt_v      = r_q.v;
    assign pt_hits   = dw_hits;
    assign pt_bits   = dw_bits;
    assign busy      = (r_q.state != SCAN_IDLE);
    assign done      = r_q.done;
    assign err       = r_q.err;
    assign res_valid = r_q.res_valid;
    assign heo       = r_q.heo;
    assign veo       = r_q.veo;
endmodule

// File: rtl/eye_scan_seq_chk.sv
module eye_scan_seq_chk #(
    parameter int PH_W   = 6,
    parameter int V_W    = 6,
    parameter int HIT_W  = 16,
    parameter int BITS_W = 32,
    parameter int RNG_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rate_ok,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              res_valid,
    input logic              pt_valid,
    input logic              pt_ready,
    input logic [PH_W-1:0]   pt_ph,
    input logic [V_W-1:0]    pt_v,
    input logic [HIT_W-1:0]  pt_hits,
    input logic [BITS_W-1:0] pt_bits,
    input logic [RNG_W-1:0]  range_o,
    input logic [PH_W:0]     heo
);
    localparam logic [PH_W:0] HEO_MAX = (PH_W+1)'(1 << PH_W);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid && !pt_ready |=> pt_valid && $stable(pt_ph) && $stable(pt_v)
                                  && $stable(pt_hits) && $stable(pt_bits));

    assert_hits_le_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> (32'(pt_hits) <= 32'(pt_bits)));

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !rate_ok && !busy |=> err && !busy);

    assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start && rate_ok && !busy |=> busy && !res_valid && !err);

    assert_done_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> res_valid && !busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !res_valid);

    assert_range_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(range_o));

    assert_stream_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |-> busy);

    assert_heo_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> heo <= HEO_MAX);
endmodule

bind eye_scan_seq eye_scan_seq_chk #(
    .PH_W(PH_W), .V_W(V_W), .HIT_W(HIT_W), .BITS_W(BITS_W), .RNG_W(RNG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rate_ok   (rate_ok),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .res_valid (res_valid),
    .pt_valid  (pt_valid),
    .pt_ready  (pt_ready),
    .pt_ph     (pt_ph),
    .pt_v      (pt_v),
    .pt_hits   (pt_hits),
    .pt_bits   (pt_bits),
    .range_o   (range_o),
    .heo       (heo)
);

// File: tb/eye_scan_seq_test.sv
`timescale 1ns/1ps
module eye_scan_seq_test;
    localparam int PH_W = 4, V_W = 4, HIT_W = 3, BITS_W = 8, RNG_W = 4;
    localparam int DL_W = 3;
    localparam int NPH = 16, NV = 16, PC = 8, VC = 8;
    localparam int HMAX = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, rate_ok = 1'b0;
    logic [DL_W-1:0] dwell_log = '0;
    logic [HIT_W-1:0] hit_thresh = '0;
    logic [RNG_W-1:0] range_cfg = '0;
    logic smp_valid = 1'b0, smp_main = 1'b0, smp_off = 1'b0;
    logic pt_ready = 1'b0;
    logic [PH_W-1:0] ph_code, pt_ph;
    logic [V_W-1:0] v_code, pt_v;
    logic [RNG_W-1:0] range_o;
    logic pt_valid, busy, done, err, res_valid;
    logic [HIT_W-1:0] pt_hits;
    logic [BITS_W-1:0] pt_bits;
    logic [PH_W:0] heo;
    logic [V_W:0] veo;

    int checks = 0, errors = 0;
    int m_pl, m_phh, m_vh, m_mq, m_mv, m_thr, m_dl, rdy_pct;
    int pt_idx = 0;
    int last_ph = -1, last_v = -1;
    bit given = 0;

    always #2.5 clk = ~clk;

    eye_scan_seq #(.PH_W(PH_W), .V_W(V_W), .HIT_W(HIT_W), .BITS_W(BITS_W), .RNG_W(RNG_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rate_ok(rate_ok),
        .dwell_log(dwell_log), .hit_thresh(hit_thresh), .range_cfg(range_cfg),
        .smp_valid(smp_valid), .smp_main(smp_main), .smp_off(smp_off),
        .ph_code(ph_code), .v_code(v_code), .range_o(range_o),
        .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_ph(pt_ph), .pt_v(pt_v),
        .pt_hits(pt_hits), .pt_bits(pt_bits), .busy(busy), .done(done),
        .err(err), .res_valid(res_valid), .heo(heo), .veo(veo));

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // eye model: 0 open, 1 marginal (one hit per dwell), 2 closed (every bit a hit)
    function automatic int cat(int ph, int v);
        int dp, dv, lim;
        dp = (ph > PC) ? ph - PC : PC - ph;
        dv = (v > VC) ? v - VC : VC - v;
        lim = m_vh - dp / 4;
        if (ph == m_mq && v == m_mv) return 1;
        if (ph < m_pl || ph > m_phh || dv > lim) return 2;
        return 0;
    endfunction

    function automatic int exp_hits(int ph, int v);
        int c;
        c = cat(ph, v);
        if (c == 2) return ((1 << m_dl) < HMAX) ? (1 << m_dl) : HMAX;
        if (c == 1) return 1;
        return 0;
    endfunction

    function automatic bit exp_open(int ph, int v);
        return exp_hits(ph, v) <= m_thr;
    endfunction

    function automatic int exp_heo();
        int n;
        if (!exp_open(PC, VC)) return 0;
        n = 1;
        for (int p = PC + 1; p < NPH && exp_open(p, VC); p++) n++;
        for (int p = PC - 1; p >= 0 && exp_open(p, VC); p--) n++;
        return n;
    endfunction

    function automatic int exp_col();
        int f, l;
        f = -1; l = -1;
        for (int p = 0; p < NPH; p++)
            if (!exp_open(p, VC)) begin
                if (f < 0) f = p;
                l = p;
            end
        return (f < 0) ? PC : (f + l) / 2;
    endfunction

    function automatic int exp_veo();
        int c, n;
        c = exp_col();
        if (!exp_open(c, VC)) return 0;
        n = 1;
        for (int v = VC + 1; v < NV && exp_open(c, v); v++) n++;
        for (int v = VC - 1; v >= 0 && exp_open(c, v); v--) n++;
        return n;
    endfunction

    // stream consumer, point checks and sampler model, all away from the active edge
    always @(negedge clk) begin
        bit r, mm;
        int c, eph, ev;
        if (rst_n) begin
            r = (($urandom % 100) < rdy_pct);
            pt_ready = r;
            if (pt_valid && r) begin
                eph = pt_idx / NV;
                ev  = pt_idx % NV;
                chk_eq("R3", "point phase index", int'(pt_ph), eph);
                chk_eq("R3", "point voltage index", int'(pt_v), ev);
                chk_eq("R3", "phase code at point", int'(ph_code), eph);
                chk_eq("R4", "bits observed", int'(pt_bits), 1 << m_dl);
                chk_eq("R5", "hit count", int'(pt_hits), exp_hits(eph, ev));
                pt_idx++;
            end
            if (int'(ph_code) != last_ph || int'(v_code) != last_v) begin
                given = 0;
                last_ph = int'(ph_code);
                last_v = int'(v_code);
            end
            smp_valid = (($urandom % 10) < 7);
            smp_main = 1'($urandom);
            c = cat(int'(ph_code), int'(v_code));
            mm = (c == 2) || (c == 1 && !given);
            if (smp_valid && c == 1) given = 1;
            smp_off = smp_main ^ mm;
        end
    end

    task automatic sweep(input int pl, phh, vh, mq, mv, thr, dl, rp, input bit poke);
        int rv, eh, evv;
        m_pl = pl; m_phh = phh; m_vh = vh; m_mq = mq; m_mv = mv;
        m_thr = thr; m_dl = dl; rdy_pct = rp; pt_idx = 0;
        rv = $urandom % 16;
        eh = exp_heo();
        evv = exp_veo();
        @(negedge clk);
        hit_thresh = HIT_W'(thr); dwell_log = DL_W'(dl); range_cfg = RNG_W'(rv);
        rate_ok = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R10", "busy after accepted start", int'(busy), 1);
        chk_eq("R10", "res_valid cleared by start", int'(res_valid), 0);
        chk_eq("R2", "err cleared by accepted start", int'(err), 0);
        chk_eq("R12", "range captured", int'(range_o), rv);
        // R12: settings changed during the sweep must not matter
        range_cfg = RNG_W'(rv ^ 15);
        dwell_log = DL_W'((dl == 1) ? 2 : 1);
        hit_thresh = HIT_W'(thr ^ 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk_eq("R11", "busy after start while busy", int'(busy), 1);
            chk_eq("R11", "no error from start while busy", int'(err), 0);
        end
        while (!done) @(negedge clk);
        chk_eq("R10", "res_valid with done", int'(res_valid), 1);
        chk_eq("R10", "busy low with done", int'(busy), 0);
        chk_eq("R3", "points emitted", pt_idx, NPH * NV);
        chk_eq("R8", "horizontal opening", int'(heo), eh);
        chk_eq("R9", "vertical opening", int'(veo), evv);
        chk_eq("R12", "range held", int'(range_o), rv);
        @(negedge clk);
        chk_eq("R10", "done lasts one cycle", int'(done), 0);
        chk_eq("R10", "results held", int'(res_valid), 1);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd4711));
        rdy_pct = 100;
        m_pl = 0; m_phh = 15; m_vh = 20; m_mq = 3; m_mv = 5; m_thr = 0; m_dl = 1;
        repeat (4) @(negedge clk);
        chk_eq("R1", "busy in reset", int'(busy), 0);
        chk_eq("R1", "pt_valid in reset", int'(pt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "busy after reset", int'(busy), 0);
        chk_eq("R1", "done after reset", int'(done), 0);
        chk_eq("R1", "err after reset", int'(err), 0);
        chk_eq("R1", "res_valid after reset", int'(res_valid), 0);

        // R2: refused start
        rate_ok = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R2", "busy after refused start", int'(busy), 0);
        chk_eq("R2", "err after refused start", int'(err), 1);
        repeat (3) @(negedge clk);
        chk_eq("R2", "no sweep after refusal", int'(pt_valid), 0);

        // wide-open eye, marginal point away from row and column
        sweep(0, 15, 20, 3, 5, 0, 2, 100, 0);
        // marginal point at the centre, threshold 0: closed centre (R7, R8, R9)
        sweep(0, 15, 20, 8, 8, 0, 1, 60, 0);
        // same with threshold 1: the single hit counts as open (R7)
        sweep(0, 15, 20, 8, 8, 1, 1, 60, 0);
        // saturating dwell, real eye edges, start while busy (R5, R11)
        sweep(3, 12, 4, 5, 9, 0, 3, 50, 1);

        // refused start after a sweep keeps err behaviour
        rate_ok = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R2", "err on second refusal", int'(err), 1);

        for (int k = 0; k < 3; k++)
            sweep($urandom % 8, 9 + $urandom % 7, $urandom % 8, 1 + $urandom % 15,
                  1 + $urandom % 15, $urandom % 2, 1 + $urandom % 3, 30 + $urandom % 71, 0);

        finish_up();
    end
endmodule